// File: doc/BRIEF.md
# Single-wire bus reset and presence master

This block carries out the reset-and-presence exchange that opens every transaction on a single-wire, open-drain serial bus. When it receives a start request, it pulls the shared data line low for a fixed number of clocks and then lets go. It then checks whether an attached slave has answered by holding the line low. It looks at the line exactly once, at a fixed delay after letting go. It then waits out the rest of the slot, raises a one-clock completion strobe and keeps the answer on a presence flag.

All three timing intervals are counted in clock cycles and set by parameters: the low-pulse length, the delay from release to sampling, and the remainder of the slot after release. Each interval has its own counter width. With the defaults and a 1 MHz clock the intervals are 512, 70 and 512 clocks. That gives a pulse of about half a millisecond and a whole exchange of about a millisecond. Each interval must be no larger than 2 to the power of its counter width, and the sampling delay must not exceed the remainder.

Top module: `ow_reset_master`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the block in idle within that edge: the bus is released, and `busy_o`, `done_o` and `present_o` are all 0. A reset during a cycle abandons that cycle.
- R2: When `start_i` is high at a clock edge while idle, the block drives the bus low from that edge for exactly LOW_CLKS clocks and then releases it.
- R3: The block only ever drives the bus low or leaves it undriven. Outside its low pulse, an unloaded bus reads high through the external pull-up.
- R4: `busy_o` rises at the edge that accepts the start and stays high for exactly LOW_CLKS + REM_CLKS clocks without a gap.
- R5: `done_o` is high for exactly one clock, in the first clock after `busy_o` falls.
- R6: `present_o` becomes 1 at completion when the bus is held low continuously from the release until past the sampling point. The sampling point is SMP_CLKS clocks after the release, and the line passes through a two-flop synchronizer before it is read.
- R7: `present_o` is 0 at completion when the line is high at the sampling point. This holds when no slave answers, when a slave pulse ends well before the sampling point, and when a slave pulse begins well after it.
- R8: A start request that arrives while `busy_o` is high is ignored: the running cycle keeps its length, and no second cycle follows it.
- R9: `present_o` keeps its value between cycles and is cleared at the edge that starts a new cycle. It reads 0 throughout the low pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to begin one reset/presence cycle |
| bus_io | inout | 1 | Open-drain data line (driven 0 or left undriven) |
| busy_o | output | 1 | High while a cycle is in progress |
| done_o | output | 1 | One-clock strobe at cycle completion |
| present_o | output | 1 | A slave answered the most recent cycle |

## Verification
The hardest case to reach from the ports is the single sampling instant. A slave answer has to be told apart by where it sits relative to that instant, not merely by whether it exists. The bench models the slave as a pull-down. It times the pull-down from the observed release and places it in three ways: covering the sampling point, ending fifteen clocks before it, and starting ten clocks after it. Only the first of these may report presence. A further run sends extra start requests in the low phase and in the listen phase, to show that they neither stretch the cycle nor chain a new one.

// File: rtl/owm_pkg.sv
`timescale 1ns/1ps
package owm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOW    = 2'd1,
        ST_LISTEN = 2'd2
    } owm_state_e;

    typedef struct packed {
        owm_state_e state;
        logic       busy;
        logic       done;
        logic       present;
        logic       drive_low;
        logic       sampled;
    } owm_regs_t;

    localparam owm_regs_t OWM_RESET = '{
        state:     ST_IDLE,
        busy:      1'b0,
        done:      1'b0,
        present:   1'b0,
        drive_low: 1'b0,
        sampled:   1'b0
    };

endpackage

// File: rtl/owm_timer.sv
`timescale 1ns/1ps
// Loadable down-counter that stops at zero.
module owm_timer #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // Once expired, the timer stays expired until it is reloaded (R4).
    p_zero_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (zero_o && !load) |=> zero_o);

endmodule

// File: rtl/owm_sync.sv
`timescale 1ns/1ps
// Flop chain that brings the asynchronous bus level into the clock domain.
module owm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                assign chain_d[g] = async_i;
            end else begin : g_next
                assign chain_d[g] = chain_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/ow_reset_master.sv
`timescale 1ns/1ps
module ow_reset_master
    import owm_pkg::*;
#(
    parameter int LOW_W    = 9,
    parameter int LOW_CLKS = 512,
    parameter int SMP_W    = 7,
    parameter int SMP_CLKS = 70,
    parameter int REM_W    = LOW_W,
    parameter int REM_CLKS = LOW_CLKS,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    inout  wire  bus_io,
    output logic busy_o,
    output logic done_o,
    output logic present_o
);
    localparam logic [LOW_W-1:0] LOW_LOAD = LOW_W'(LOW_CLKS - 1);
    localparam logic [SMP_W-1:0] SMP_LOAD = SMP_W'(SMP_CLKS - 1);
    localparam logic [REM_W-1:0] REM_LOAD = REM_W'(REM_CLKS - 1);

    owm_regs_t r_d, r_q;

    logic low_load, smp_load, rem_load;
    logic low_zero, smp_zero, rem_zero;
    logic bus_sync;

    // Open-drain output: pull low or float.
    assign bus_io = r_q.drive_low ? 1'b0 : 1'bz;

    owm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (bus_io),
        .sync_o  (bus_sync)
    );

    owm_timer #(.W(LOW_W)) u_low_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (low_load),
        .load_val (LOW_LOAD),
        .run      (r_q.state == ST_LOW),
        .zero_o   (low_zero)
    );

    owm_timer #(.W(SMP_W)) u_smp_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (smp_load),
        .load_val (SMP_LOAD),
        .run      (r_q.state == ST_LISTEN),
        .zero_o   (smp_zero)
    );

    owm_timer #(.W(REM_W)) u_rem_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (rem_load),
        .load_val (REM_LOAD),
        .run      (r_q.state == ST_LISTEN),
        .zero_o   (rem_zero)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        low_load = 1'b0;
        smp_load = 1'b0;
        rem_load = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state     = ST_LOW;
                    r_d.busy      = 1'b1;
                    r_d.drive_low = 1'b1;
                    r_d.present   = 1'b0;
                    r_d.sampled   = 1'b0;
                    low_load      = 1'b1;
                end
            end
            ST_LOW: begin
                if (low_zero) begin
                    r_d.state     = ST_LISTEN;
                    r_d.drive_low = 1'b0;
                    smp_load      = 1'b1;
                    rem_load      = 1'b1;
                end
            end
            ST_LISTEN: begin
                if (smp_zero && !r_q.sampled) begin
                    r_d.present = ~bus_sync;
                    r_d.sampled = 1'b1;
                end
                if (rem_zero) begin
                    r_d.state = ST_IDLE;
                    r_d.busy  = 1'b0;
                    r_d.done  = 1'b1;
                end
            end
            default: r_d = OWM_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= OWM_RESET;
        else     r_q <= r_d;
    end

    assign busy_o    = r_q.busy;
    assign done_o    = r_q.done;
    assign present_o = r_q.present;

    // Completion strobe lasts one clock (R5).
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // Busy only falls together with the completion strobe (R5).
    p_done_with_fall_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);

    // The line is only pulled while a cycle runs (R2).
    p_drive_in_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        r_q.drive_low |-> busy_o);

    // Busy holds until the remainder timer expires, whatever start does (R8).
    p_busy_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !(r_q.state == ST_LISTEN && rem_zero)) |=> busy_o);

    // Presence reads 0 through the low pulse (R9).
    p_present_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_LOW) |-> !present_o);

    // After the single sample, presence is frozen until a new start (R6).
    p_single_sample_r6: assert property (@(posedge clk) disable iff (rst)
        (r_q.sampled && !(r_q.state == ST_IDLE && start_i)) |=> $stable(present_o));

endmodule

// File: tb/sim_ow_reset_master.sv
`timescale 1ns/1ps
module sim_ow_reset_master;
    localparam int L = 512;
    localparam int R = 512;
    localparam int S = 70;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic go  = 1'b0;
    logic slave_low = 1'b0;
    wire  owbus;
    logic busy, done, present;
    int   n_checks = 0;
    int   n_fail   = 0;

    always #5 clk = ~clk;

    pullup (owbus);
    assign owbus = slave_low ? 1'b0 : 1'bz;

    ow_reset_master u0 (
        .clk       (clk),
        .rst       (rst),
        .start_i   (go),
        .bus_io    (owbus),
        .busy_o    (busy),
        .done_o    (done),
        .present_o (present)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        check(busy == 1'b0,    {req, " busy"},    busy,    0);
        check(done == 1'b0,    {req, " done"},    done,    0);
        check(present == 1'b0, {req, " present"}, present, 0);
        check(owbus === 1'b1,  {req, " bus"},     int'(owbus === 1'b1), 1);
    endtask

    // One full cycle. The slave pulls low for indices [L+1+a, L+1+b) after the start.
    // Index i is the i-th falling edge after the edge that accepts the start.
    task automatic run_cycle(input string name, input int a, input int b,
                             input bit exp_p, input bit extra_go);
        int busy_n = 0;
        int line_err = 0;
        int done_n = 0;
        int done_at = -1;
        int pres_bad = 0;
        @(negedge clk) go = 1'b1;
        @(negedge clk) go = 1'b0;
        for (int i = 1; i <= L + R + 4; i++) begin
            if (i > 1) @(negedge clk);
            slave_low = (i >= L + 1 + a) && (i < L + 1 + b);
            if (extra_go) go = (i == 200) || (i == L + 100);
            #1;
            if (busy) busy_n++;
            if (i <= L) begin
                if (owbus !== 1'b0) line_err++;
                if (present) pres_bad++;
            end else if (!slave_low && owbus !== 1'b1) begin
                line_err++;
            end
            if (done) begin
                done_n++;
                done_at = i;
            end
        end
        slave_low = 1'b0;
        go = 1'b0;
        check(busy_n == L + R, {name, " R4/R8 busy length"}, busy_n, L + R);
        check(line_err == 0, {name, " R2/R3 low pulse and release"}, line_err, 0);
        check(done_n == 1, {name, " R5 done count"}, done_n, 1);
        check(done_at == L + R + 1, {name, " R5 done position"}, done_at, L + R + 1);
        check(pres_bad == 0, {name, " R9 present low in pulse"}, pres_bad, 0);
        check(present == exp_p, {name, " R6/R7 presence"}, present, exp_p);
    endtask

    task automatic t_reset_idle();
        @(negedge clk);
        check_idle("R1 after reset");
    endtask

    task automatic t_reset_clears();
        // present is 1 here: reset in idle must clear it
        check(present == 1'b1, "R9 present held between cycles", present, 1);
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        #1;
        check_idle("R1 reset clears present");
    endtask

    task automatic t_reset_mid();
        @(negedge clk) go = 1'b1;
        @(negedge clk) go = 1'b0;
        repeat (100) @(negedge clk);
        #1;
        check(owbus === 1'b0, "R2 bus low mid pulse", int'(owbus === 1'b0), 1);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        check_idle("R1 reset mid cycle");
        repeat (L + R) @(negedge clk);
        #1;
        check(busy == 1'b0, "R1 no resumption after reset", busy, 0);
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset_idle();
        run_cycle("present",    0,      S + 20, 1'b1, 1'b0);
        run_cycle("no slave",   R + 10, R + 10, 1'b0, 1'b0);
        run_cycle("late pulse", S + 10, S + 60, 1'b0, 1'b0);
        run_cycle("early pulse", 2,     S - 15, 1'b0, 1'b0);
        run_cycle("start while busy", 0, S + 20, 1'b1, 1'b1);
        t_reset_clears();
        t_reset_mid();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule